// File: doc/BRIEF.md
# Ethernet PHY Energy-Aware Power State Controller

This block decides when the datapath of an Ethernet PHY has power, when it may move data, and when it is held in reset. Software drives it through a small register port. One control bit forces a hard power-down. Clearing that bit brings the PHY back through a timed reset pulse, and the configuration field returns to its default value. A second bit turns on an automatic sleep mode. In that mode the datapath powers off once the line has been quiet for a programmable number of cycles. The register port, the squelch input and the activity input keep working while the datapath sleeps.

While the PHY sleeps, any energy reported by the squelch detector, or any activity strobe from a link pulse or packet, starts a wake sequence. The datapath powers up at once but stays disabled for a fixed settling window. Receive and transmit are therefore suppressed, and the first frame or two on the line may be lost. The configuration that was in place before sleep is kept unchanged. A sticky wake flag records the event and can raise an interrupt when it is unmasked. Transmission is inhibited whenever the datapath is not enabled. The hard power-down always overrides the automatic sleep mode.

Top module: `phy_pwr_mgr`

## Requirements
- R1: While rst_n is low and for RST_CYC cycles after it rises, phy_rst is 1, dp_pwr_on is 1, dp_en is 0, tx_inhibit is 1, wake_irq is 0 and cfg_out equals CFG_DEFAULT. After those cycles dp_en becomes 1.
- R2: Writing 1 to bit 0 (hard power-down) of the control register at address 0 drives dp_pwr_on and dp_en to 0 one cycle after the write takes effect.
- R3: tx_inhibit is 1 whenever dp_en is 0. In sleep and in hard power-down, dp_pwr_on and dp_en are both 0.
- R4: With bit 1 (automatic sleep) of address 0 set and bit 0 clear, the datapath powers off after exactly N consecutive cycles with energy_on and rx_act both low. N is the value at address 1, and 0 is treated as 1. Any activity restarts the count.
- R5: While the hard power-down bit is set, energy_on and rx_act neither power the datapath nor set the wake flag.
- R6: Clearing the power-down bit starts, one cycle later, a phy_rst pulse of RST_CYC cycles, after which dp_en becomes 1. cfg_out is reloaded to CFG_DEFAULT at the start of the pulse.
- R7: In sleep, energy_on or rx_act powers the datapath on in the next cycle. dp_en stays 0 for WAKE_CYC cycles and then becomes 1. cfg_out keeps its pre-sleep value.
- R8: A wake caused by energy or activity sets the sticky flag, which reads as bit 0 of address 2. The flag stays set until address 2 is read, and the read clears it.
- R9: wake_irq is 1 exactly when the wake flag and the mask bit (bit 0 of address 3) are both 1.
- R10: Reading address 0 returns {cfg[5:0], auto-sleep, power-down}, address 1 returns the idle limit, address 3 returns the mask. A write to the configuration field takes effect on cfg_out even while the datapath sleeps.
- R11: Clearing the auto-sleep bit during sleep runs the wake sequence without setting the wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 2 clears the flag) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| energy_on | input | 1 | Line energy present, from the squelch detector |
| rx_act | input | 1 | Link pulse or packet activity strobe |
| dp_pwr_on | output | 1 | Datapath power enable |
| dp_en | output | 1 | Datapath ready to transmit and receive |
| tx_inhibit | output | 1 | Forces transmit-enable inactive |
| phy_rst | output | 1 | PHY reset pulse |
| cfg_out | output | 6 | Current PHY configuration field |
| wake_irq | output | 1 | Masked wake interrupt |

## Verification
The bench sweeps the idle limit from 0 through 6 and checks that the datapath is still enabled one cycle before the limit and is off exactly at the limit. A counter that is off by one, or that treats a limit of 0 as "never", fails this sweep. A single activity strobe in the middle of a quiet stretch must restart the count, which exposes a count that only pauses. Each wake is timed through the settling window and checked for a retained configuration, while release from hard power-down is checked for a reloaded default. Swapping those two paths, or raising the interrupt while masked, shows up at the ports. Energy applied during hard power-down must not wake the PHY or set the flag, and leaving sleep by clearing the mode bit must also leave the flag clear.

// File: rtl/phy_pwr_pkg.sv
// Shared types and register layout for the PHY power state controller.
// Assumes a 2-bit register address space; field bit positions are fixed here.
package phy_pwr_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_WAKE   = 3'd3,
        ST_PDN    = 3'd4
    } pwr_state_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LIMIT = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;
    localparam logic [1:0] ADDR_MASK  = 2'd3;

    localparam int CTRL_PDN_BIT = 0;
    localparam int CTRL_EDM_BIT = 1;
    localparam int CTRL_CFG_LSB = 2;

endpackage

// File: rtl/phy_pwr_regs.sv
// Register bank: control bits, configuration field, idle limit, sticky
// wake flag and its mask. Assumes DATA_W >= CFG_W + 2 and DATA_W >= IDLE_W.
// A configuration reload from the state machine overrides a software write.
module phy_pwr_regs
    import phy_pwr_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter int                CFG_W        = 6,
    parameter int                IDLE_W       = 8,
    parameter logic [CFG_W-1:0]  CFG_DEFAULT  = 'h15,
    parameter logic [IDLE_W-1:0] IDLE_DEFAULT = 'd16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cfg_reload,
    input  logic              wake_pulse,
    output logic              pdn,
    output logic              edm_en,
    output logic [CFG_W-1:0]  cfg,
    output logic [IDLE_W-1:0] idle_limit,
    output logic              wake_flag,
    output logic              wake_mask
);

    logic wr_ctrl, wr_limit, wr_mask, rd_stat;

    // Decode register strobes per address.
    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
        wr_limit = reg_wr && (reg_addr == ADDR_LIMIT);
        wr_mask  = reg_wr && (reg_addr == ADDR_MASK);
        rd_stat  = reg_rd && (reg_addr == ADDR_STAT);
    end

    // Control bits and configuration field; reload to default wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn    <= 1'b0;
            edm_en <= 1'b0;
            cfg    <= CFG_DEFAULT;
        end else begin
            if (wr_ctrl) begin
                pdn    <= reg_wdata[CTRL_PDN_BIT];
                edm_en <= reg_wdata[CTRL_EDM_BIT];
                cfg    <= reg_wdata[CTRL_CFG_LSB +: CFG_W];
            end
            if (cfg_reload) begin
                cfg <= CFG_DEFAULT;
            end
        end
    end

    // Idle limit and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_limit <= IDLE_DEFAULT;
            wake_mask  <= 1'b0;
        end else begin
            if (wr_limit) idle_limit <= reg_wdata[IDLE_W-1:0];
            if (wr_mask)  wake_mask  <= reg_wdata[0];
        end
    end

    // Sticky wake flag: set by a wake event, cleared by reading its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_flag <= 1'b0;
        end else if (wake_pulse) begin
            wake_flag <= 1'b1;
        end else if (rd_stat) begin
            wake_flag <= 1'b0;
        end
    end

    // Read data mux, zero padded to the bus width.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_PDN_BIT]              = pdn;
                reg_rdata[CTRL_EDM_BIT]              = edm_en;
                reg_rdata[CTRL_CFG_LSB +: CFG_W]     = cfg;
            end
            ADDR_LIMIT: reg_rdata[IDLE_W-1:0] = idle_limit;
            ADDR_STAT:  reg_rdata[0]          = wake_flag;
            default:    reg_rdata[0]          = wake_mask;
        endcase
    end

endmodule

// File: rtl/phy_idle_timer.sv
// Counts consecutive quiet cycles while armed and flags when the streak
// reaches the programmed limit. A limit of zero behaves as one. Any
// activity, or disarming, clears the streak. The count saturates.
module phy_idle_timer #(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              quiet,
    input  logic [IDLE_W-1:0] limit,
    output logic              expired
);

    localparam logic [IDLE_W-1:0] CNT_MAX = '1;

    logic [IDLE_W-1:0] cnt;
    logic [IDLE_W:0]   eff_lim;
    logic [IDLE_W:0]   next_cnt;

    // Effective limit and the streak length including this cycle.
    always_comb begin
        eff_lim  = (limit == '0) ? (IDLE_W+1)'(1) : {1'b0, limit};
        next_cnt = {1'b0, cnt} + (IDLE_W+1)'(1);
        expired  = armed && quiet && (next_cnt >= eff_lim);
    end

    // Quiet-streak counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!armed || !quiet) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/phy_pwr_fsm.sv
// Power state machine: reset pulse, active, energy-detect sleep, wake
// settling and hard power-down. Hard power-down has priority over every
// other transition. Assumes RST_CYC and WAKE_CYC are at least 1.
module phy_pwr_fsm
    import phy_pwr_pkg::*;
#(
    parameter int RST_CYC  = 4,
    parameter int WAKE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn,
    input  logic       edm_en,
    input  logic       idle_expired,
    input  logic       energy_on,
    input  logic       rx_act,
    output pwr_state_t state,
    output logic       idle_armed,
    output logic       cfg_reload,
    output logic       wake_pulse,
    output logic       dp_pwr_on,
    output logic       dp_en,
    output logic       tx_inhibit,
    output logic       phy_rst
);

    localparam int MAX_CYC = (RST_CYC > WAKE_CYC) ? RST_CYC : WAKE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYC - 1);

    pwr_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             line_live;

    // Next-state selection with hard power-down taking priority.
    always_comb begin
        line_live = energy_on || rx_act;
        nxt       = state;
        case (state)
            ST_RESET:  if (cnt == '0) nxt = ST_ACTIVE;
            ST_ACTIVE: if (idle_expired) nxt = ST_SLEEP;
            ST_SLEEP:  if (line_live || !edm_en) nxt = ST_WAKE;
            ST_WAKE:   if (cnt == '0) nxt = ST_ACTIVE;
            ST_PDN:    if (!pdn) nxt = ST_RESET;
            default:   nxt = ST_RESET;
        endcase
        if (pdn && state != ST_PDN) nxt = ST_PDN;
    end

    // State register and settling-window down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RESET;
            cnt   <= RST_LOAD;
        end else begin
            state <= nxt;
            if (nxt != state && nxt == ST_RESET) begin
                cnt <= RST_LOAD;
            end else if (nxt != state && nxt == ST_WAKE) begin
                cnt <= WAKE_LOAD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Event strobes toward the register bank and idle timer.
    always_comb begin
        idle_armed = (state == ST_ACTIVE) && edm_en && !pdn;
        cfg_reload = (state == ST_PDN) && !pdn;
        wake_pulse = (state == ST_SLEEP) && !pdn && line_live;
    end

    // Power and enable outputs decoded from the state register.
    always_comb begin
        dp_pwr_on  = (state == ST_RESET) || (state == ST_ACTIVE) || (state == ST_WAKE);
        dp_en      = (state == ST_ACTIVE);
        tx_inhibit = !dp_en;
        phy_rst    = (state == ST_RESET);
    end

endmodule

// File: rtl/phy_pwr_mgr.sv
// Top of the PHY power state controller. Joins the register bank, the
// idle timer and the power state machine. Assumes energy_on and rx_act
// are already synchronous to clk.
module phy_pwr_mgr
    import phy_pwr_pkg::*;
#(
    parameter int                DATA_W       = 8,
    parameter int                CFG_W        = 6,
    parameter int                IDLE_W       = 8,
    parameter logic [CFG_W-1:0]  CFG_DEFAULT  = 'h15,
    parameter logic [IDLE_W-1:0] IDLE_DEFAULT = 'd16,
    parameter int                RST_CYC      = 4,
    parameter int                WAKE_CYC     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              energy_on,
    input  logic              rx_act,
    output logic              dp_pwr_on,
    output logic              dp_en,
    output logic              tx_inhibit,
    output logic              phy_rst,
    output logic [CFG_W-1:0]  cfg_out,
    output logic              wake_irq
);

    pwr_state_t        fsm_state;
    logic              pdn_q, edm_q, wake_flag, wake_mask;
    logic [IDLE_W-1:0] idle_limit;
    logic              idle_armed, idle_expired, cfg_reload, wake_pulse;
    logic              quiet;

    // Line is quiet when neither energy nor activity is reported.
    always_comb begin
        quiet    = !energy_on && !rx_act;
        wake_irq = wake_flag && wake_mask;
    end

    phy_pwr_regs #(
        .DATA_W       (DATA_W),
        .CFG_W        (CFG_W),
        .IDLE_W       (IDLE_W),
        .CFG_DEFAULT  (CFG_DEFAULT),
        .IDLE_DEFAULT (IDLE_DEFAULT)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cfg_reload (cfg_reload),
        .wake_pulse (wake_pulse),
        .pdn        (pdn_q),
        .edm_en     (edm_q),
        .cfg        (cfg_out),
        .idle_limit (idle_limit),
        .wake_flag  (wake_flag),
        .wake_mask  (wake_mask)
    );

    phy_idle_timer #(
        .IDLE_W (IDLE_W)
    ) i_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (idle_armed),
        .quiet   (quiet),
        .limit   (idle_limit),
        .expired (idle_expired)
    );

    phy_pwr_fsm #(
        .RST_CYC  (RST_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pdn          (pdn_q),
        .edm_en       (edm_q),
        .idle_expired (idle_expired),
        .energy_on    (energy_on),
        .rx_act       (rx_act),
        .state        (fsm_state),
        .idle_armed   (idle_armed),
        .cfg_reload   (cfg_reload),
        .wake_pulse   (wake_pulse),
        .dp_pwr_on    (dp_pwr_on),
        .dp_en        (dp_en),
        .tx_inhibit   (tx_inhibit),
        .phy_rst      (phy_rst)
    );

endmodule

// File: rtl/phy_pwr_chk.sv
// Property checker for the PHY power state controller, bound to the top.
// Observes the state register, control bits and port behaviour.
module phy_pwr_chk
    import phy_pwr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input pwr_state_t state,
    input logic       pdn,
    input logic       energy_on,
    input logic       rx_act,
    input logic       wake_flag,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       dp_pwr_on,
    input logic       dp_en,
    input logic       tx_inhibit,
    input logic       phy_rst
);

    a_r3_off_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP || state == ST_PDN) |-> (tx_inhibit && !dp_en && !dp_pwr_on));

    a_r2_pdn_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn && state != ST_PDN) |=> (state == ST_PDN));

    a_r5_pdn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDN && pdn) |=> (state == ST_PDN && !dp_pwr_on));

    a_r6_rst_after_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PDN && !pdn) |=> phy_rst);

    a_r4_sleep_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SLEEP) |-> $past(!energy_on && !rx_act));

    a_r7_wake_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !pdn && (energy_on || rx_act)) |=> (wake_flag && state == ST_WAKE));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !(reg_rd && reg_addr == ADDR_STAT)) |=> wake_flag);

endmodule

bind phy_pwr_mgr phy_pwr_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_state),
    .pdn        (pdn_q),
    .energy_on  (energy_on),
    .rx_act     (rx_act),
    .wake_flag  (wake_flag),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .dp_pwr_on  (dp_pwr_on),
    .dp_en      (dp_en),
    .tx_inhibit (tx_inhibit),
    .phy_rst    (phy_rst)
);

// File: tb/test_phy_pwr_mgr.sv
// Self-checking bench for the PHY power state controller.
module test_phy_pwr_mgr;

    localparam int             RST_CYC  = 4;
    localparam int             WAKE_CYC = 3;
    localparam logic [5:0]     CFG_DEF  = 6'h15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       energy_on = 1'b0, rx_act = 1'b0;
    logic       dp_pwr_on, dp_en, tx_inhibit, phy_rst, wake_irq;
    logic [5:0] cfg_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    phy_pwr_mgr #(
        .DATA_W(8), .CFG_W(6), .IDLE_W(8), .CFG_DEFAULT(CFG_DEF),
        .IDLE_DEFAULT(8'd16), .RST_CYC(RST_CYC), .WAKE_CYC(WAKE_CYC)
    ) i_phy_pwr_mgr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .energy_on(energy_on), .rx_act(rx_act), .dp_pwr_on(dp_pwr_on),
        .dp_en(dp_en), .tx_inhibit(tx_inhibit), .phy_rst(phy_rst),
        .cfg_out(cfg_out), .wake_irq(wake_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Control word: {cfg, auto-sleep, power-down}.
    function automatic logic [7:0] ctrl(input logic [5:0] c, input logic e, input logic p);
        return {c, e, p};
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int eff;
        tick(3);
        // R1: reset state
        chk("R1 rst", phy_rst, 1); chk("R1 pwr", dp_pwr_on, 1);
        chk("R1 en", dp_en, 0); chk("R1 txinh", tx_inhibit, 1);
        chk("R1 irq", wake_irq, 0); chk("R1 cfg", cfg_out, CFG_DEF);
        rst_n = 1'b1;
        tick(RST_CYC - 1);
        chk("R1 rst held", phy_rst, 1);
        tick(1);
        chk("R1 rst done", phy_rst, 0); chk("R1 en after", dp_en, 1);

        // R10: register read-back of defaults
        rd(2'd1, 8'd16, "R10 limit");
        rd(2'd0, ctrl(CFG_DEF, 0, 0), "R10 ctrl");
        rd(2'd2, 8'd0, "R8 flag clear");
        rd(2'd3, 8'd0, "R10 mask");

        energy_on = 1'b1;
        wr(2'd0, ctrl(6'h2A, 1, 0));
        chk("R10 cfg write", cfg_out, 6'h2A);

        // R4/R7/R8: sweep idle limits, wake alternately by energy and activity
        for (int lim = 0; lim <= 6; lim++) begin
            wr(2'd1, 8'(lim));
            energy_on = 1'b0;
            eff = (lim == 0) ? 1 : lim;
            if (eff > 1) begin
                tick(eff - 1);
                chk("R4 before limit", dp_en, 1);
            end
            tick(1);
            chk("R4 at limit pwr", dp_pwr_on, 0);
            chk("R3 sleep txinh", tx_inhibit, 1);
            if (lim % 2 == 0) begin
                energy_on = 1'b1;
                tick(1);
            end else begin
                rx_act = 1'b1;
                tick(1);
                rx_act = 1'b0; energy_on = 1'b1;
            end
            chk("R7 wake pwr", dp_pwr_on, 1);
            chk("R7 wake en", dp_en, 0);
            chk("R7 cfg kept", cfg_out, 6'h2A);
            tick(WAKE_CYC - 1);
            chk("R7 settling", dp_en, 0);
            tick(1);
            chk("R7 active", dp_en, 1);
            rd(2'd2, 8'd1, "R8 flag set");
            rd(2'd2, 8'd0, "R8 read clears");
        end

        // R4: activity restarts the quiet count
        wr(2'd1, 8'd5);
        energy_on = 1'b0;
        tick(3);
        rx_act = 1'b1; tick(1); rx_act = 1'b0;
        tick(4);
        chk("R4 restart", dp_en, 1);
        tick(1);
        chk("R4 restart sleep", dp_pwr_on, 0);

        // R10: management works while asleep
        wr(2'd0, ctrl(6'h0F, 1, 0));
        chk("R10 cfg asleep", cfg_out, 6'h0F);
        chk("R10 still asleep", dp_pwr_on, 0);

        // R11: clearing auto-sleep wakes without flag
        wr(2'd0, ctrl(6'h0F, 0, 0));
        tick(1);
        chk("R11 pwr", dp_pwr_on, 1);
        tick(WAKE_CYC);
        chk("R11 en", dp_en, 1);
        rd(2'd2, 8'd0, "R11 no flag");

        // R9: masked interrupt
        wr(2'd3, 8'd0);
        wr(2'd0, ctrl(6'h0F, 1, 0));
        tick(5);
        chk("R4 sleep again", dp_pwr_on, 0);
        energy_on = 1'b1;
        tick(1);
        chk("R9 masked", wake_irq, 0);
        wr(2'd3, 8'd1);
        chk("R9 unmasked", wake_irq, 1);
        rd(2'd3, 8'd1, "R10 mask read");
        rd(2'd2, 8'd1, "R9 flag");
        chk("R9 cleared", wake_irq, 0);
        tick(WAKE_CYC);

        // R2/R5: hard power-down ignores line activity
        wr(2'd0, ctrl(6'h0F, 1, 1));
        tick(1);
        chk("R2 pwr off", dp_pwr_on, 0);
        chk("R2 en off", dp_en, 0);
        chk("R3 pdn txinh", tx_inhibit, 1);
        energy_on = 1'b0; tick(10);
        energy_on = 1'b1; rx_act = 1'b1; tick(3); rx_act = 1'b0;
        chk("R5 stays off", dp_pwr_on, 0);
        rd(2'd2, 8'd0, "R5 no flag");

        // R6: release gives reset pulse and default configuration
        wr(2'd0, ctrl(6'h2A, 1, 0));
        tick(1);
        chk("R6 rst", phy_rst, 1);
        chk("R6 cfg default", cfg_out, CFG_DEF);
        tick(RST_CYC - 1);
        chk("R6 rst held", phy_rst, 1);
        tick(1);
        chk("R6 rst end", phy_rst, 0);
        chk("R6 en", dp_en, 1);
        rd(2'd0, ctrl(CFG_DEF, 1, 0), "R6 ctrl read");

        // R5: power-down from sleep, energy ignored
        energy_on = 1'b0;
        tick(5);
        chk("R4 sleep 3", dp_pwr_on, 0);
        wr(2'd0, ctrl(CFG_DEF, 1, 1));
        tick(1);
        energy_on = 1'b1;
        tick(5);
        chk("R5 sleep pdn off", dp_pwr_on, 0);
        rd(2'd2, 8'd0, "R5 sleep no flag");
        wr(2'd0, ctrl(CFG_DEF, 1, 0));
        tick(1);
        chk("R6 rst 2", phy_rst, 1);
        tick(RST_CYC);
        chk("R6 en 2", dp_en, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule